// File: doc/BRIEF.md
# Virtual Page Translation Lookup Unit

This block turns an address-space identifier and a virtual page number into a real page number and four permission flags. Before it consults its table, it sorts each request into one of four paths. An all-ones identifier is passed through unchanged. A page inside a configurable bypass window is relocated arithmetically. A page inside a configurable shared window is looked up as if its identifier were zero. Every other request is looked up under its own identifier.

The table is direct-mapped. It is indexed by XOR-folding the page number and the identifier down to the index width. Each slot holds the identifier, the page bits above the index, the real page and the flags. The low page bits are not stored: they are rebuilt from the slot index when the tag is compared. A write port replaces a whole slot or clears it. There is no partial update.

Requests enter the pipeline with a single-cycle strobe. Each one answers exactly two clock cycles later. The area windows are supplied as pattern/mask/base inputs, and these are expected to stay steady while lookups are in flight.

Top module: `pageXlateUnit`

## Requirements
- R1: A lookup whose identifier is all ones answers hit = 1, real page = virtual page, and flags = the fixed value.
- R2: A page is in the bypass window when (vp & bypassMask) == (bypassPattern & bypassMask). Such a lookup answers hit = 1, real page = (bypassBase & bypassMask) | (vp & ~bypassMask), and the fixed flags.
- R3: A page is in the shared window when (vp & sharedMask) == (sharedPattern & sharedMask). Such a lookup searches the table with identifier 0. Writes always use the identifier given on the write port.
- R4: The path priority is fixed: identity beats bypass, bypass beats shared, and shared beats an ordinary table search.
- R5: Flags are 4 bits: bit 3 dirty, bit 2 kernel write, bit 1 user write, bit 0 user read. The fixed value is 4'b1100.
- R6: The slot index is the XOR of all IDX_W-wide chunks of the zero-padded page and of the zero-padded identifier. With the defaults this is vp[7:0]^vp[15:8]^vp[21:16]^aid[7:0]^aid[15:8].
- R7: A table hit needs three things: the slot is valid, the rebuilt page equals the requested page, and the stored identifier equals the search identifier. The hit then returns the stored real page and flags. A miss answers hit = 0, real page = 0 and flags = 0.
- R8: A write with entry-valid = 0 clears the addressed slot, so a later lookup of that page misses.
- R9: A valid write replaces the whole slot. An earlier entry that shares the slot index then misses, while entries in other slots still hit.
- R10: A write is dropped when its identifier is all ones or its page lies in the bypass window. The slot it would have addressed keeps its old contents.
- R11: rspValid pulses for one cycle exactly two cycles after each reqValid cycle. Back-to-back requests answer on back-to-back cycles. rspHit is low whenever rspValid is low.
- R12: A lookup issued in the same cycle as a write to its slot sees the old contents. A lookup issued in the following cycle sees the new contents.
- R13: After reset there is no response pending, and every slot is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Lookup strobe |
| reqAid | input | AID_W | Lookup address-space identifier |
| reqVp | input | PAGE_W | Lookup virtual page |
| cfgSharedPattern | input | PAGE_W | Shared window pattern |
| cfgSharedMask | input | PAGE_W | Shared window mask |
| cfgBypassPattern | input | PAGE_W | Bypass window pattern |
| cfgBypassMask | input | PAGE_W | Bypass window mask |
| cfgBypassBase | input | PAGE_W | Bypass relocation base |
| wrValid | input | 1 | Entry write strobe |
| wrAid | input | AID_W | Entry identifier |
| wrVp | input | PAGE_W | Entry virtual page |
| wrRp | input | PAGE_W | Entry real page |
| wrFlags | input | 4 | Entry flags |
| wrEntryValid | input | 1 | 1 installs the entry, 0 clears the slot |
| rspValid | output | 1 | Response strobe |
| rspHit | output | 1 | Translation found |
| rspRp | output | PAGE_W | Real page |
| rspFlags | output | 4 | Permission flags |

## Verification
The bench builds the unit with PAGE_W = 10, AID_W = 8 and IDX_W = 4. This gives a 1024-page space folded onto a 16-slot table. At that size the bench can sweep every page through the identity path and every bypass page through the relocation formula. It also fills the table page by page, so that slot collisions happen all the time and eviction can be predicted from an arithmetic index model. The small identifier makes it cheap to search for pages that collide under a dropped write, which proves that such a write leaves the slot untouched.

// File: rtl/pxuPkg.sv
package pxuPkg;

  localparam int FLAG_W = 4;

  // Flag layout: [3] dirty, [2] kernel write, [1] user write, [0] user read
  localparam logic [FLAG_W-1:0] FIXED_FLAGS = 4'b1100;

  typedef enum logic [1:0] {
    PATH_IDENT,
    PATH_BYPASS,
    PATH_SHARED,
    PATH_TABLE
  } path_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic  tblWrite;    // accepted entry write this cycle
    logic  s1Load;      // capture lookup into stage 1
    logic  s2Load;      // form response from stage 1
    logic  useZeroAid;  // stage-0 lookup searches with identifier 0
    path_e s2Path;      // path of the request held in stage 1
  } strobes_t;

endpackage

// File: rtl/pxuCtrl.sv
module pxuCtrl
  import pxuPkg::*;
#(
  parameter int AID_W  = 16,
  parameter int PAGE_W = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [AID_W-1:0]  reqAid,
  input  logic [PAGE_W-1:0] reqVp,
  input  logic              wrValid,
  input  logic [AID_W-1:0]  wrAid,
  input  logic [PAGE_W-1:0] wrVp,
  input  logic [PAGE_W-1:0] cfgSharedPattern,
  input  logic [PAGE_W-1:0] cfgSharedMask,
  input  logic [PAGE_W-1:0] cfgBypassPattern,
  input  logic [PAGE_W-1:0] cfgBypassMask,
  output strobes_t          stb,
  output logic              rspValid
);

  function automatic logic inWindow(input logic [PAGE_W-1:0] vp,
                                    input logic [PAGE_W-1:0] pat,
                                    input logic [PAGE_W-1:0] mask);
    return (vp & mask) == (pat & mask);
  endfunction

  logic  reqIdent;
  logic  reqBypass;
  logic  reqShared;
  path_e reqPath;
  logic  wrAccept;

  logic  s1Valid;
  path_e s1Path;

  assign reqIdent  = &reqAid;
  assign reqBypass = inWindow(reqVp, cfgBypassPattern, cfgBypassMask);
  assign reqShared = inWindow(reqVp, cfgSharedPattern, cfgSharedMask);

  // Ordered decision: identity, bypass, shared, plain table
  always_comb begin
    if (reqIdent)       reqPath = PATH_IDENT;
    else if (reqBypass) reqPath = PATH_BYPASS;
    else if (reqShared) reqPath = PATH_SHARED;
    else                reqPath = PATH_TABLE;
  end

  // Writes aimed at computed regions are dropped
  assign wrAccept = wrValid && !(&wrAid) &&
                    !inWindow(wrVp, cfgBypassPattern, cfgBypassMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      s1Path   <= PATH_IDENT;
      rspValid <= 1'b0;
    end else begin
      s1Valid  <= reqValid;
      rspValid <= s1Valid;
      if (reqValid) s1Path <= reqPath;
    end
  end

  always_comb begin
    stb.tblWrite   = wrAccept;
    stb.s1Load     = reqValid;
    stb.s2Load     = s1Valid;
    stb.useZeroAid = (reqPath == PATH_SHARED);
    stb.s2Path     = s1Path;
  end

endmodule

// File: rtl/pxuData.sv
module pxuData
  import pxuPkg::*;
#(
  parameter int AID_W  = 16,
  parameter int PAGE_W = 22,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [AID_W-1:0]  reqAid,
  input  logic [PAGE_W-1:0] reqVp,
  input  logic [AID_W-1:0]  wrAid,
  input  logic [PAGE_W-1:0] wrVp,
  input  logic [PAGE_W-1:0] wrRp,
  input  logic [FLAG_W-1:0] wrFlags,
  input  logic              wrEntryValid,
  input  logic [PAGE_W-1:0] cfgBypassMask,
  input  logic [PAGE_W-1:0] cfgBypassBase,
  output logic              rspHit,
  output logic [PAGE_W-1:0] rspRp,
  output logic [FLAG_W-1:0] rspFlags
);

  localparam int DEPTH  = 1 << IDX_W;
  localparam int TAG_W  = PAGE_W - IDX_W;
  localparam int VP_CH  = (PAGE_W + IDX_W - 1) / IDX_W;
  localparam int AID_CH = (AID_W + IDX_W - 1) / IDX_W;

  typedef struct packed {
    logic [TAG_W-1:0]  vpHi;
    logic [AID_W-1:0]  aid;
    logic [PAGE_W-1:0] rp;
    logic [FLAG_W-1:0] flags;
  } entry_t;

  // XOR-fold of zero-padded page and identifier into IDX_W bits
  function automatic logic [IDX_W-1:0] hashIdx(input logic [PAGE_W-1:0] vp,
                                               input logic [AID_W-1:0]  aid);
    logic [VP_CH*IDX_W-1:0]  vpPad;
    logic [AID_CH*IDX_W-1:0] aidPad;
    logic [IDX_W-1:0]        acc;
    vpPad  = '0;
    aidPad = '0;
    vpPad[PAGE_W-1:0] = vp;
    aidPad[AID_W-1:0] = aid;
    acc = '0;
    for (int i = 0; i < VP_CH; i++)  acc ^= vpPad[i*IDX_W +: IDX_W];
    for (int i = 0; i < AID_CH; i++) acc ^= aidPad[i*IDX_W +: IDX_W];
    return acc;
  endfunction

  // Stage 0: search key and slot addresses
  logic [AID_W-1:0] lkAid;
  logic [IDX_W-1:0] lkIdx;
  logic [IDX_W-1:0] wrIdx;
  entry_t           wrEntry;

  assign lkAid = stb.useZeroAid ? '0 : reqAid;
  assign lkIdx = hashIdx(reqVp, lkAid);
  assign wrIdx = hashIdx(wrVp, wrAid);

  always_comb begin
    wrEntry.vpHi  = wrVp[PAGE_W-1:IDX_W];
    wrEntry.aid   = wrAid;
    wrEntry.rp    = wrRp;
    wrEntry.flags = wrFlags;
  end

  // Table storage (no reset) and per-slot valid bits (reset)
  entry_t           tbl [DEPTH];
  logic [DEPTH-1:0] slotValid;

  always_ff @(posedge clk) begin
    if (stb.tblWrite) tbl[wrIdx] <= wrEntry;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    logic vq;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                       vq <= 1'b0;
      else if (stb.tblWrite && wrIdx == IDX_W'(g))     vq <= wrEntryValid;
    end
    assign slotValid[g] = vq;
  end

  // Stage 1: registered table read plus request copy
  entry_t            s1Entry;
  logic              s1EntValid;
  logic [IDX_W-1:0]  s1Idx;
  logic [PAGE_W-1:0] s1Vp;
  logic [AID_W-1:0]  s1Aid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Entry    <= '0;
      s1EntValid <= 1'b0;
      s1Idx      <= '0;
      s1Vp       <= '0;
      s1Aid      <= '0;
    end else if (stb.s1Load) begin
      s1Entry    <= tbl[lkIdx];
      s1EntValid <= slotValid[lkIdx];
      s1Idx      <= lkIdx;
      s1Vp       <= reqVp;
      s1Aid      <= lkAid;
    end
  end

  // Tag check: low page bits rebuilt from slot index and stored fields
  logic [IDX_W-1:0]  recLow;
  logic [PAGE_W-1:0] recVp;
  logic              tagHit;
  logic [PAGE_W-1:0] bypassRp;

  assign recLow   = s1Idx ^ hashIdx({s1Entry.vpHi, {IDX_W{1'b0}}}, s1Entry.aid);
  assign recVp    = {s1Entry.vpHi, recLow};
  assign tagHit   = s1EntValid && (recVp == s1Vp) && (s1Entry.aid == s1Aid);
  assign bypassRp = (cfgBypassBase & cfgBypassMask) | (s1Vp & ~cfgBypassMask);

  // Stage 2: response registers, cleared when no response is due
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspHit   <= 1'b0;
      rspRp    <= '0;
      rspFlags <= '0;
    end else if (stb.s2Load) begin
      unique case (stb.s2Path)
        PATH_IDENT: begin
          rspHit   <= 1'b1;
          rspRp    <= s1Vp;
          rspFlags <= FIXED_FLAGS;
        end
        PATH_BYPASS: begin
          rspHit   <= 1'b1;
          rspRp    <= bypassRp;
          rspFlags <= FIXED_FLAGS;
        end
        default: begin
          rspHit   <= tagHit;
          rspRp    <= tagHit ? s1Entry.rp : '0;
          rspFlags <= tagHit ? s1Entry.flags : '0;
        end
      endcase
    end else begin
      rspHit   <= 1'b0;
      rspRp    <= '0;
      rspFlags <= '0;
    end
  end

endmodule

// File: rtl/pageXlateUnit.sv
module pageXlateUnit
  import pxuPkg::*;
#(
  parameter int AID_W  = 16,
  parameter int PAGE_W = 22,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [AID_W-1:0]  reqAid,
  input  logic [PAGE_W-1:0] reqVp,
  input  logic [PAGE_W-1:0] cfgSharedPattern,
  input  logic [PAGE_W-1:0] cfgSharedMask,
  input  logic [PAGE_W-1:0] cfgBypassPattern,
  input  logic [PAGE_W-1:0] cfgBypassMask,
  input  logic [PAGE_W-1:0] cfgBypassBase,
  input  logic              wrValid,
  input  logic [AID_W-1:0]  wrAid,
  input  logic [PAGE_W-1:0] wrVp,
  input  logic [PAGE_W-1:0] wrRp,
  input  logic [3:0]        wrFlags,
  input  logic              wrEntryValid,
  output logic              rspValid,
  output logic              rspHit,
  output logic [PAGE_W-1:0] rspRp,
  output logic [3:0]        rspFlags
);

  strobes_t stb;

  pxuCtrl #(.AID_W(AID_W), .PAGE_W(PAGE_W)) ctrl (
    .clk              (clk),
    .rstN             (rstN),
    .reqValid         (reqValid),
    .reqAid           (reqAid),
    .reqVp            (reqVp),
    .wrValid          (wrValid),
    .wrAid            (wrAid),
    .wrVp             (wrVp),
    .cfgSharedPattern (cfgSharedPattern),
    .cfgSharedMask    (cfgSharedMask),
    .cfgBypassPattern (cfgBypassPattern),
    .cfgBypassMask    (cfgBypassMask),
    .stb              (stb),
    .rspValid         (rspValid)
  );

  pxuData #(.AID_W(AID_W), .PAGE_W(PAGE_W), .IDX_W(IDX_W)) data (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .reqAid        (reqAid),
    .reqVp         (reqVp),
    .wrAid         (wrAid),
    .wrVp          (wrVp),
    .wrRp          (wrRp),
    .wrFlags       (wrFlags),
    .wrEntryValid  (wrEntryValid),
    .cfgBypassMask (cfgBypassMask),
    .cfgBypassBase (cfgBypassBase),
    .rspHit        (rspHit),
    .rspRp         (rspRp),
    .rspFlags      (rspFlags)
  );

endmodule

// File: rtl/pageXlateUnit_chk.sv
module pageXlateUnit_chk #(
  parameter int AID_W  = 16,
  parameter int PAGE_W = 22
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [AID_W-1:0]  reqAid,
  input logic [PAGE_W-1:0] reqVp,
  input logic [PAGE_W-1:0] cfgBypassPattern,
  input logic [PAGE_W-1:0] cfgBypassMask,
  input logic [PAGE_W-1:0] cfgBypassBase,
  input logic              rspValid,
  input logic              rspHit,
  input logic [PAGE_W-1:0] rspRp,
  input logic [3:0]        rspFlags
);

  logic reqInBypass;
  assign reqInBypass = (reqVp & cfgBypassMask) == (cfgBypassPattern & cfgBypassMask);

  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> ##2 rspValid); // R11

  AST_RSP_ORIGIN: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid, 2)); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> !rspHit); // R11

  AST_IDENT_MAP: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (&reqAid)) |-> ##2
      (rspHit && rspRp == $past(reqVp, 2) && rspFlags == 4'b1100)); // R1

  AST_BYPASS_MAP: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !(&reqAid) && reqInBypass) |-> ##2
      (rspHit && rspFlags == 4'b1100 &&
       rspRp == ((cfgBypassBase & cfgBypassMask) | ($past(reqVp, 2) & ~cfgBypassMask)))); // R2

  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> (rspRp == '0 && rspFlags == '0)); // R7

endmodule

bind pageXlateUnit pageXlateUnit_chk #(.AID_W(AID_W), .PAGE_W(PAGE_W)) chk (
  .clk              (clk),
  .rstN             (rstN),
  .reqValid         (reqValid),
  .reqAid           (reqAid),
  .reqVp            (reqVp),
  .cfgBypassPattern (cfgBypassPattern),
  .cfgBypassMask    (cfgBypassMask),
  .cfgBypassBase    (cfgBypassBase),
  .rspValid         (rspValid),
  .rspHit           (rspHit),
  .rspRp            (rspRp),
  .rspFlags         (rspFlags)
);

// File: tb/pageXlateUnit_test.sv
module pageXlateUnit_test;

  localparam int AW = 8;
  localparam int PW = 10;
  localparam int IW = 4;
  localparam int CF = 12; // fixed flags 4'b1100

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [AW-1:0] reqAid = '0;
  logic [PW-1:0] reqVp = '0;
  logic [PW-1:0] cfgSharedPattern, cfgSharedMask;
  logic [PW-1:0] cfgBypassPattern, cfgBypassMask, cfgBypassBase;
  logic          wrValid = 1'b0;
  logic [AW-1:0] wrAid = '0;
  logic [PW-1:0] wrVp = '0;
  logic [PW-1:0] wrRp = '0;
  logic [3:0]    wrFlags = '0;
  logic          wrEntryValid = 1'b0;
  logic          rspValid, rspHit;
  logic [PW-1:0] rspRp;
  logic [3:0]    rspFlags;

  int  nChecks = 0;
  int  nErrors = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  pageXlateUnit #(.AID_W(AW), .PAGE_W(PW), .IDX_W(IW)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAid(reqAid), .reqVp(reqVp),
    .cfgSharedPattern(cfgSharedPattern), .cfgSharedMask(cfgSharedMask),
    .cfgBypassPattern(cfgBypassPattern), .cfgBypassMask(cfgBypassMask),
    .cfgBypassBase(cfgBypassBase), .wrValid(wrValid), .wrAid(wrAid), .wrVp(wrVp),
    .wrRp(wrRp), .wrFlags(wrFlags), .wrEntryValid(wrEntryValid),
    .rspValid(rspValid), .rspHit(rspHit), .rspRp(rspRp), .rspFlags(rspFlags)
  );

  function automatic int hashB(input int aid, input int vp);
    return (vp ^ (vp >> 4) ^ (vp >> 8) ^ aid ^ (aid >> 4)) & 15;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input int aid, input int vp, input int rp, input int fl, input bit v);
    @(negedge clk);
    wrValid = 1'b1; wrAid = aid[AW-1:0]; wrVp = vp[PW-1:0];
    wrRp = rp[PW-1:0]; wrFlags = fl[3:0]; wrEntryValid = v;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic lookupChk(input int aid, input int vp, input bit eHit,
                           input int eRp, input int eFl, input string tag);
    logic [PW-1:0] er;
    logic [3:0]    ef;
    er = eRp[PW-1:0];
    ef = eFl[3:0];
    @(negedge clk);
    reqValid = 1'b1; reqAid = aid[AW-1:0]; reqVp = vp[PW-1:0];
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    check(tag, {16'h0, rspValid, rspHit, rspRp, rspFlags}, {16'h0, 1'b1, eHit, er, ef});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    int idxX, y, z, k;
    // top bits 11 = bypass, 10 = shared, 0x = ordinary
    cfgBypassMask = 10'h300; cfgBypassPattern = 10'h300; cfgBypassBase = 10'h100;
    cfgSharedMask = 10'h300; cfgSharedPattern = 10'h200;
    repeat (3) @(negedge clk);
    check("R13 no response in reset", {31'h0, rspValid}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R13 no response after reset", {31'h0, rspValid}, 32'h0);

    // R13: every ordinary page misses on a fresh table
    for (int vp = 0; vp < 512; vp++) lookupChk(5, vp, 1'b0, 0, 0, "R13 empty table miss");

    // R1 R4 R5: identity path wins for every page, including bypass and shared ones
    for (int vp = 0; vp < 1024; vp++) lookupChk(255, vp, 1'b1, vp, CF, "R1 R4 R5 identity");

    // R2: bypass relocation across the whole window
    for (int vp = 768; vp < 1024; vp++)
      lookupChk(3, vp, 1'b1, 256 | (vp & 255), CF, "R2 bypass relocation");

    // R6 R7 R9 R12: fill page by page, predicting evictions from the index model
    for (int vp = 0; vp < 512; vp++) begin
      doWrite(7, vp, (vp ^ 10'h2A5), vp & 15, 1'b1);
      lookupChk(7, vp, 1'b1, vp ^ 10'h2A5, vp & 15, "R7 R12 hit after write");
      lookupChk(6, vp, 1'b0, 0, 0, "R7 aid mismatch miss");
      if (vp > 0) begin
        if (hashB(7, vp - 1) == hashB(7, vp))
          lookupChk(7, vp - 1, 1'b0, 0, 0, "R6 R9 colliding entry replaced");
        else
          lookupChk(7, vp - 1, 1'b1, (vp - 1) ^ 10'h2A5, (vp - 1) & 15, "R6 R9 other slot kept");
      end
    end

    // R3: shared pages found under identifier 0 whatever the requester
    for (int vp = 512; vp < 768; vp++) begin
      doWrite(0, vp, (~vp) & 1023, (vp & 15) ^ 9, 1'b1);
      lookupChk(51, vp, 1'b1, (~vp) & 1023, (vp & 15) ^ 9, "R3 shared uses aid 0");
    end

    // R4: bypass beats shared when the windows overlap; R3 with a widened window
    @(negedge clk);
    cfgSharedMask = 10'h000; cfgSharedPattern = 10'h000;
    lookupChk(3, 10'h3A5, 1'b1, 256 | 10'h0A5, CF, "R4 bypass over shared");
    doWrite(0, 10'h055, 10'h0AA, 5, 1'b1);
    lookupChk(4, 10'h055, 1'b1, 10'h0AA, 5, "R3 shared widened window");
    @(negedge clk);
    cfgSharedMask = 10'h300; cfgSharedPattern = 10'h200;

    // R8: flush
    doWrite(7, 10'h0C3, 10'h111, 15, 1'b1);
    lookupChk(7, 10'h0C3, 1'b1, 10'h111, 15, "R8 before flush");
    doWrite(7, 10'h0C3, 0, 0, 1'b0);
    lookupChk(7, 10'h0C3, 1'b0, 0, 0, "R8 after flush");

    // R10: dropped writes aimed at the slot of a live entry
    doWrite(7, 10'h012, 10'h222, 6, 1'b1);
    idxX = hashB(7, 10'h012);
    y = 0;
    for (int v = 0; v < 1024; v++) if (hashB(255, v) == idxX) y = v;
    doWrite(255, y, 0, 0, 1'b0);
    lookupChk(7, 10'h012, 1'b1, 10'h222, 6, "R10 identity write dropped");
    z = 768;
    for (int v = 768; v < 1024; v++) if (hashB(7, v) == idxX) z = v;
    doWrite(7, z, 0, 0, 1'b0);
    lookupChk(7, 10'h012, 1'b1, 10'h222, 6, "R10 bypass write dropped");

    // R12: same-cycle write and lookup sees old contents
    doWrite(7, 10'h044, 10'h0F0, 3, 1'b1);
    @(negedge clk);
    wrValid = 1'b1; wrAid = 8'd7; wrVp = 10'h044; wrEntryValid = 1'b0;
    reqValid = 1'b1; reqAid = 8'd7; reqVp = 10'h044;
    @(negedge clk);
    wrValid = 1'b0; reqValid = 1'b0;
    @(negedge clk);
    check("R12 same-cycle lookup sees old", {16'h0, rspValid, rspHit, rspRp, rspFlags},
          {16'h0, 1'b1, 1'b1, 10'h0F0, 4'd3});
    lookupChk(7, 10'h044, 1'b0, 0, 0, "R12 next lookup sees flush");

    // R11: single pulse exactly two cycles later
    @(negedge clk);
    reqValid = 1'b1; reqAid = 8'hFF; reqVp = 10'd5;
    @(negedge clk);
    reqValid = 1'b0;
    check("R11 no response after one cycle", {31'h0, rspValid}, 32'h0);
    @(negedge clk);
    check("R11 response after two cycles", {31'h0, rspValid}, 32'h1);
    @(negedge clk);
    check("R11 pulse is one cycle", {30'h0, rspValid, rspHit}, 32'h0);

    // R11: back-to-back requests answer on back-to-back cycles
    @(negedge clk);
    reqValid = 1'b1; reqAid = 8'hFF; reqVp = 10'd100;
    @(negedge clk);
    reqVp = 10'd101;
    @(negedge clk);
    reqVp = 10'd102;
    check("R11 pipelined first", {16'h0, rspValid, rspRp}, {16'h0, 1'b1, 10'd100});
    @(negedge clk);
    reqValid = 1'b0;
    check("R11 pipelined second", {16'h0, rspValid, rspRp}, {16'h0, 1'b1, 10'd101});
    @(negedge clk);
    check("R11 pipelined third", {16'h0, rspValid, rspRp}, {16'h0, 1'b1, 10'd102});
    k = 0;
    @(negedge clk);
    check("R11 pipeline drained", {31'h0, rspValid}, 32'(k));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule